// File: doc/BRIEF.md
# Batched 128-bit Memory Transfer Requester with Per-CTU Deadline

This block sits between a video encoder core and an external memory controller. The core hands it one transfer descriptor at a time. A descriptor gives the direction, a word count in 128-bit words, a start word address and a flag that marks the first batch of a coding-tree unit (CTU). The engine raises a request toward memory and holds it until the controller acknowledges. In the data phase it then either streams write words on the controller's pull strobe or passes read words on to the core when the controller marks them valid.

Write data is fall-through. The core supplies the word at the index the engine exposes on `wr_idx_o`, combinationally. Word 0 sits on the memory data bus while the request is high. Each pull strobe moves the index on within the same cycle. Batches are grouped per CTU. A descriptor carrying the first flag opens a CTU window and starts a deadline timer, and at most four descriptors fit in one window. If any batch is still in flight when the deadline expires, a sticky error is raised, and only reset clears it. As soon as one batch ends, the engine accepts the next descriptor, so a chained batch requests again in the next cycle.

Top module: `ddr_batch_engine`

## Requirements
- R1: `mem_req_o` rises in the cycle after a descriptor with a nonzero count is accepted. It stays high until a cycle in which `mem_ack_i` is high, and it is low in the cycle after that acknowledge and for the rest of that batch's data phase.
- R2: While `mem_req_o` is high, `mem_write_o` (1 = write, 0 = read), `mem_first_o`, `mem_len_o` and `mem_addr_o` equal the accepted descriptor's fields and do not change.
- R3: Word k of a batch (k from 0) has word address `mem_addr_o + k`. For reads it appears on `rd_addr_o`. For writes it is `mem_addr_o + wr_idx_o` in the cycle that word is on the bus.
- R4: For writes, `mem_wdata_o` equals `wr_data_i`, and `wr_idx_o` is 0 while the request is high. The index holds until the first `mem_wpull_i`, and the k-th pull cycle exposes index k within that same cycle.
- R5: `rd_valid_o` is high only in read data-phase cycles with `mem_rvalid_i` high, and it then carries `mem_rdata_i`. A `mem_rvalid_i` at any other time is ignored.
- R6: A write batch of n words completes after n-1 pulls (n = 1 completes in the first data-phase cycle). A read batch completes on its n-th valid word. `desc_ready_o` is high in the completing cycle, and a descriptor presented then raises `mem_req_o` in the very next cycle.
- R7: A descriptor with the first flag set opens a CTU window and takes slot one. Non-first descriptors take further slots, up to four per window. A fifth one is accepted but dropped, and no request is raised for it.
- R8: A descriptor with a zero word count is accepted and raises no request. It still uses a CTU slot.
- R9: If a batch is still in flight (not completing) in the 8400th cycle after the edge that accepted the CTU's first descriptor, `ctu_err_o` goes high and stays high until reset.
- R10: While `rst_ni` is low, `mem_req_o`, `rd_valid_o` and `ctu_err_o` are low and `desc_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Encoder clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| desc_valid_i | input | 1 | Descriptor presented |
| desc_ready_o | output | 1 | Descriptor accepted this cycle when valid |
| desc_write_i | input | 1 | 1 = write batch, 0 = read batch |
| desc_first_i | input | 1 | First batch of a CTU |
| desc_len_i | input | 10 | Word count in 128-bit words |
| desc_addr_i | input | 28 | Start word address |
| mem_req_o | output | 1 | Batch request to memory |
| mem_ack_i | input | 1 | Request acknowledge pulse |
| mem_write_o | output | 1 | Batch direction |
| mem_first_o | output | 1 | First-of-CTU flag of the batch |
| mem_len_o | output | 10 | Batch word count |
| mem_addr_o | output | 28 | Batch start word address |
| mem_wpull_i | input | 1 | Write data pull strobe |
| mem_wdata_o | output | 128 | Write data, fall-through |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 128 | Read data |
| wr_idx_o | output | 10 | Index of the write word the core must supply |
| wr_data_i | input | 128 | Write word for `wr_idx_o` |
| rd_valid_o | output | 1 | Forwarded read word valid |
| rd_data_o | output | 128 | Forwarded read word |
| rd_addr_o | output | 28 | Word address of the forwarded read word |
| ctu_err_o | output | 1 | Sticky CTU deadline overrun |

## Verification
The assertions assume that the memory side pulses `mem_ack_i` only while a request is pending. They also assume it never pulls or returns more words than the batch holds, and that the core keeps descriptor fields steady while `desc_valid_i` waits for ready. The stimulus keeps within these limits: acknowledges come only after the request is seen, exactly n-1 pulls or n valid words are given per batch, and descriptors are dropped only after a ready cycle. The one deliberate exception is read-valid pulses during the request phase, which exercise the ignore rule. Deadline cases place a batch's completion exactly in the last allowed cycle and one cycle later.

// File: rtl/ddr_batch_pkg.sv
package ddr_batch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2
  } batch_st_e;
endpackage

// File: rtl/ddr_batch_fsm.sv
module ddr_batch_fsm
  import ddr_batch_pkg::*;
#(
  parameter int unsigned LEN_W  = 10,
  parameter int unsigned ADDR_W = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              d_write_i,
  input  logic              d_first_i,
  input  logic [LEN_W-1:0]  d_len_i,
  input  logic [ADDR_W-1:0] d_addr_i,
  input  logic              mem_ack_i,
  input  logic              mem_wpull_i,
  input  logic              mem_rvalid_i,
  output logic              mem_req_o,
  output logic              mem_write_o,
  output logic              mem_first_o,
  output logic [LEN_W-1:0]  mem_len_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LEN_W-1:0]  wr_idx_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned LX = LEN_W + 1;

  batch_st_e         st_q;
  logic              wr_q, first_q;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic [ADDR_W-1:0] addr_q;

  logic in_data, step_w, step_r, wr_last, rd_last;

  assign in_data = (st_q == ST_DATA);
  assign step_w  = in_data && wr_q && mem_wpull_i;
  assign step_r  = in_data && !wr_q && mem_rvalid_i;
  // word 0 goes with the request, so n-1 pulls finish a write
  assign wr_last = (len_q == LEN_W'(1)) ||
                   (mem_wpull_i && (({1'b0, cnt_q} + LX'(2)) == {1'b0, len_q}));
  assign rd_last = mem_rvalid_i && (({1'b0, cnt_q} + LX'(1)) == {1'b0, len_q});
  assign done_o  = in_data && (wr_q ? wr_last : rd_last);
  assign busy_o  = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      first_q <= 1'b0;
      len_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else if (issue_i) begin
      st_q    <= ST_REQ;
      wr_q    <= d_write_i;
      first_q <= d_first_i;
      len_q   <= d_len_i;
      addr_q  <= d_addr_i;
      cnt_q   <= '0;
    end else if (done_o) begin
      st_q <= ST_IDLE;
    end else if (st_q == ST_REQ && mem_ack_i) begin
      st_q <= ST_DATA;
    end else if (step_w || step_r) begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  assign mem_req_o   = (st_q == ST_REQ);
  assign mem_write_o = wr_q;
  assign mem_first_o = first_q;
  assign mem_len_o   = len_q;
  assign mem_addr_o  = addr_q;
  assign wr_idx_o    = cnt_q + LEN_W'(step_w);
  assign rd_valid_o  = step_r;
  assign rd_addr_o   = addr_q + ADDR_W'(cnt_q);

  p_req_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o);
  p_req_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> !mem_req_o);
  p_fields_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> $stable(mem_len_o) && $stable(mem_addr_o) &&
                                $stable(mem_write_o) && $stable(mem_first_o));
  p_len_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_len_o != '0);
  p_rd_consec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o || rd_addr_o == $past(rd_addr_o) + ADDR_W'(1));
  p_rd_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> mem_rvalid_i && !mem_req_o);
endmodule

// File: rtl/ddr_ctu_timer.sv
module ddr_ctu_timer #(
  parameter int unsigned DEADLINE  = 8400,
  parameter int unsigned MAX_BATCH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic first_i,
  input  logic busy_i,
  input  logic done_i,
  output logic slot_ok_o,
  output logic err_o
);
  localparam int unsigned TMR_W  = $clog2(DEADLINE);
  localparam int unsigned SLOT_W = $clog2(MAX_BATCH + 1);

  logic [TMR_W-1:0]  tmr_q;
  logic [SLOT_W-1:0] slot_q;
  logic              open_q, err_q;
  logic              room;

  assign room      = (slot_q < SLOT_W'(MAX_BATCH));
  assign slot_ok_o = first_i || room;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
    end else if (acc_i) begin
      if (first_i)   slot_q <= SLOT_W'(1);
      else if (room) slot_q <= slot_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      open_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (acc_i && first_i) begin
      tmr_q  <= '0;
      open_q <= 1'b1;
    end else if (open_q) begin
      if (tmr_q == TMR_W'(DEADLINE - 1)) begin
        open_q <= 1'b0;
        if (busy_i && !done_i) err_q <= 1'b1;
      end else begin
        tmr_q <= tmr_q + TMR_W'(1);
      end
    end
  end

  assign err_o = err_q;

  p_slots_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= SLOT_W'(MAX_BATCH));
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_err_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> err_o == $past(err_o));
endmodule

// File: rtl/ddr_batch_engine.sv
module ddr_batch_engine #(
  parameter int unsigned LEN_W     = 10,
  parameter int unsigned ADDR_W    = 28,
  parameter int unsigned DATA_W    = 128,
  parameter int unsigned MAX_BATCH = 4,
  parameter int unsigned DEADLINE  = 8400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              desc_valid_i,
  output logic              desc_ready_o,
  input  logic              desc_write_i,
  input  logic              desc_first_i,
  input  logic [LEN_W-1:0]  desc_len_i,
  input  logic [ADDR_W-1:0] desc_addr_i,
  output logic              mem_req_o,
  input  logic              mem_ack_i,
  output logic              mem_write_o,
  output logic              mem_first_o,
  output logic [LEN_W-1:0]  mem_len_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_wpull_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [LEN_W-1:0]  wr_idx_o,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              ctu_err_o
);
  logic busy, done, slot_ok, acc, issue;

  assign desc_ready_o = !busy || done;
  assign acc          = desc_valid_i && desc_ready_o;
  assign issue        = acc && (desc_len_i != '0) && slot_ok;

  ddr_batch_fsm #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_i      (issue),
    .d_write_i    (desc_write_i),
    .d_first_i    (desc_first_i),
    .d_len_i      (desc_len_i),
    .d_addr_i     (desc_addr_i),
    .mem_ack_i    (mem_ack_i),
    .mem_wpull_i  (mem_wpull_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_req_o    (mem_req_o),
    .mem_write_o  (mem_write_o),
    .mem_first_o  (mem_first_o),
    .mem_len_o    (mem_len_o),
    .mem_addr_o   (mem_addr_o),
    .wr_idx_o     (wr_idx_o),
    .rd_valid_o   (rd_valid_o),
    .rd_addr_o    (rd_addr_o),
    .busy_o       (busy),
    .done_o       (done)
  );

  ddr_ctu_timer #(.DEADLINE(DEADLINE), .MAX_BATCH(MAX_BATCH)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .first_i   (desc_first_i),
    .busy_i    (busy),
    .done_i    (done),
    .slot_ok_o (slot_ok),
    .err_o     (ctu_err_o)
  );

  // fall-through: the core answers wr_idx_o combinationally
  assign mem_wdata_o = wr_data_i;
  assign rd_data_o   = mem_rdata_i;

  p_first_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_write_o |-> wr_idx_o == '0);
  p_chain_next_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && desc_valid_i && desc_len_i != '0 && slot_ok |=> mem_req_o);
endmodule

// File: tb/sim_ddr_batch_engine.sv
module sim_ddr_batch_engine;
  typedef struct {
    bit           w;
    logic [27:0]  a;
    logic [127:0] d;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic desc_valid_i = 0, desc_write_i = 0, desc_first_i = 0;
  logic [9:0]  desc_len_i = '0;
  logic [27:0] desc_addr_i = '0;
  logic mem_ack_i = 0, mem_wpull_i = 0, mem_rvalid_i = 0;
  logic [127:0] mem_rdata_i = '0;
  logic [127:0] wr_data_i;
  logic desc_ready_o, mem_req_o, mem_write_o, mem_first_o, rd_valid_o, ctu_err_o;
  logic [9:0]   mem_len_o, wr_idx_o;
  logic [27:0]  mem_addr_o, rd_addr_o;
  logic [127:0] mem_wdata_o, rd_data_o;

  int n_chk = 0, n_fail = 0;
  item_t exp_q[$];
  logic [27:0] cur_base = '0;
  bit nx_w, nx_f;
  int nx_len;
  logic [27:0] nx_a;
  bit prev_req = 0;

  always #4 clk = ~clk;

  function automatic logic [127:0] wpat(logic [27:0] a);
    return {4'hA, a, 4'h5, ~a, 32'h1234_0000 ^ {4'h0, a}, 4'h3, a};
  endfunction
  function automatic logic [127:0] rpat(logic [27:0] a);
    return {4'hC, ~a, 4'h7, a, 4'h9, a, 32'h0BAD_0000 ^ {4'h0, a}};
  endfunction

  assign wr_data_i = wpat(cur_base + 28'(wr_idx_o));

  ddr_batch_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .desc_valid_i(desc_valid_i), .desc_ready_o(desc_ready_o),
    .desc_write_i(desc_write_i), .desc_first_i(desc_first_i),
    .desc_len_i(desc_len_i), .desc_addr_i(desc_addr_i),
    .mem_req_o(mem_req_o), .mem_ack_i(mem_ack_i),
    .mem_write_o(mem_write_o), .mem_first_o(mem_first_o),
    .mem_len_o(mem_len_o), .mem_addr_o(mem_addr_o),
    .mem_wpull_i(mem_wpull_i), .mem_wdata_o(mem_wdata_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .wr_idx_o(wr_idx_o), .wr_data_i(wr_data_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_addr_o(rd_addr_o),
    .ctu_err_o(ctu_err_o)
  );

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask
  task automatic smp(); #3; endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pops expected words as they appear on the ports
  task automatic observe(bit w, logic [27:0] a, logic [127:0] d);
    item_t e;
    if (exp_q.size() == 0) begin
      chk(0, w ? "R4 unexpected write word" : "R5 unexpected read word", d, 0);
    end else begin
      e = exp_q.pop_front();
      chk(e.w == w && e.a == a && e.d == d,
          w ? "R3/R4 write word addr+data" : "R3/R5 read word addr+data",
          {a, d[99:0]}, {e.a, e.d[99:0]});
    end
  endtask

  initial begin
    forever begin
      @(negedge clk); #3;
      if (rst_ni) begin
        if (mem_req_o && !prev_req && mem_write_o)
          observe(1, mem_addr_o + 28'(wr_idx_o), mem_wdata_o);
        if (mem_wpull_i) observe(1, mem_addr_o + 28'(wr_idx_o), mem_wdata_o);
        if (rd_valid_o)  observe(0, rd_addr_o, rd_data_o);
        prev_req = mem_req_o;
      end else prev_req = 0;
    end
  end

  task automatic present(bit w, bit f, int len, logic [27:0] a);
    desc_valid_i = 1; desc_write_i = w; desc_first_i = f;
    desc_len_i = 10'(len); desc_addr_i = a;
  endtask

  task automatic push_exp(bit w, int len, logic [27:0] a);
    for (int i = 0; i < len; i++) begin
      item_t it;
      it.w = w; it.a = a + 28'(i);
      it.d = w ? wpat(a + 28'(i)) : rpat(a + 28'(i));
      exp_q.push_back(it);
    end
  endtask

  // one batch; pre = request already raised by a chained accept
  task automatic do_batch(bit w, bit f, int len, logic [27:0] a,
                          int ackdly, int gap, bit chain, bit pre);
    push_exp(w, len, a);
    if (!pre) begin
      cyc(); if (w) cur_base = a; present(w, f, len, a); smp();
      chk(desc_ready_o == 1, "R6 ready while idle", desc_ready_o, 1);
      cyc(); desc_valid_i = 0; smp();
    end
    chk(mem_req_o == 1, "R1 request raised", mem_req_o, 1);
    chk(mem_write_o == w && mem_first_o == f && mem_len_o == 10'(len) && mem_addr_o == a,
        "R2 request fields", {mem_write_o, mem_first_o, mem_len_o, mem_addr_o},
        {w, f, 10'(len), a});
    for (int k = 0; k < ackdly; k++) begin
      cyc(); if (!w) begin mem_rvalid_i = 1; mem_rdata_i = '1; end smp();
      chk(mem_req_o == 1 && mem_len_o == 10'(len) && mem_addr_o == a,
          "R1/R2 request held", mem_req_o, 1);
      if (w) chk(mem_wdata_o == wpat(a), "R4 word 0 with request", mem_wdata_o, wpat(a));
      else   chk(rd_valid_o == 0, "R5 read valid ignored in request", rd_valid_o, 0);
    end
    cyc(); mem_rvalid_i = 0; mem_ack_i = 1; smp();
    chk(mem_req_o == 1, "R1 request at ack", mem_req_o, 1);
    cyc(); mem_ack_i = 0; smp();
    chk(mem_req_o == 0, "R1 request low after ack", mem_req_o, 0);
    if (w && len == 1) chk(desc_ready_o == 1, "R6 single write done", desc_ready_o, 1);
    if (w) begin
      for (int i = 1; i < len; i++) begin
        for (int g = 0; g < gap; g++) begin
          cyc(); mem_wpull_i = 0; smp();
          chk(mem_req_o == 0, "R1 low in data phase", mem_req_o, 0);
          chk(mem_wdata_o == wpat(a + 28'(i - 1)), "R4 word held between pulls",
              mem_wdata_o, wpat(a + 28'(i - 1)));
        end
        cyc(); mem_wpull_i = 1;
        if (i == len - 1 && chain) present(nx_w, nx_f, nx_len, nx_a);
        smp();
        if (i == len - 1) chk(desc_ready_o == 1, "R6 ready on last pull", desc_ready_o, 1);
        else chk(desc_ready_o == 0, "R6 busy mid batch", desc_ready_o, 0);
      end
    end else begin
      for (int i = 0; i < len; i++) begin
        for (int g = 0; g < gap; g++) begin
          cyc(); mem_rvalid_i = 0; smp();
          chk(rd_valid_o == 0 && mem_req_o == 0, "R5 no read without valid", rd_valid_o, 0);
        end
        cyc(); mem_rvalid_i = 1; mem_rdata_i = rpat(a + 28'(i));
        if (i == len - 1 && chain) present(nx_w, nx_f, nx_len, nx_a);
        smp();
        if (i == len - 1) chk(desc_ready_o == 1, "R6 ready on last read", desc_ready_o, 1);
      end
    end
    cyc(); mem_wpull_i = 0; mem_rvalid_i = 0; desc_valid_i = 0;
    if (chain && nx_w) cur_base = nx_a;
    smp();
    if (chain) chk(mem_req_o == 1, "R6 chained request next cycle", mem_req_o, 1);
    else       chk(mem_req_o == 0 && desc_ready_o == 1, "R6 idle after batch", mem_req_o, 0);
  endtask

  task automatic drop_desc(bit f, int len, logic [27:0] a, string req);
    cyc(); present(0, f, len, a); smp();
    chk(desc_ready_o == 1, req, desc_ready_o, 1);
    cyc(); desc_valid_i = 0; smp();
    for (int k = 0; k < 3; k++) begin
      chk(mem_req_o == 0, req, mem_req_o, 0);
      cyc(); smp();
    end
  endtask

  // read of one word, first of CTU, completing wcount cycles after accept
  task automatic deadline_read(logic [27:0] a, int waits);
    push_exp(0, 1, a);
    cyc(); present(0, 1, 1, a); smp();            // S0: accepted at next edge
    cyc(); desc_valid_i = 0; mem_ack_i = 1; smp(); // S1
    for (int k = 0; k < waits; k++) begin
      cyc(); mem_ack_i = 0; smp();
    end
    cyc(); mem_rvalid_i = 1; mem_rdata_i = rpat(a); smp();
    chk(rd_valid_o == 1, "R9 deadline read word", rd_valid_o, 1);
    cyc(); mem_rvalid_i = 0; smp();
  endtask

  initial begin
    #(8 * 190000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    #2;
    chk(mem_req_o == 0 && rd_valid_o == 0 && ctu_err_o == 0 && desc_ready_o == 1,
        "R10 reset state", {mem_req_o, rd_valid_o, ctu_err_o, desc_ready_o}, 4'b0001);
    repeat (3) @(negedge clk);
    rst_ni = 1;

    do_batch(1, 1, 4, 28'h100, 2, 1, 0, 0);   // slot 1
    do_batch(0, 0, 5, 28'h200, 3, 2, 0, 0);   // slot 2
    do_batch(1, 0, 1, 28'h300, 0, 0, 0, 0);   // slot 3
    do_batch(0, 0, 2, 28'h400, 1, 0, 0, 0);   // slot 4
    drop_desc(0, 3, 28'h500, "R7 fifth batch dropped");

    nx_w = 0; nx_f = 0; nx_len = 2; nx_a = 28'h600;
    do_batch(1, 1, 3, 28'h580, 1, 0, 1, 0);
    do_batch(0, 0, 2, 28'h600, 0, 1, 0, 1);
    drop_desc(0, 0, 28'h700, "R8 zero count no request");
    do_batch(1, 0, 2, 28'h7F0, 0, 0, 0, 0);
    chk(exp_q.size() == 0, "R6 all words transferred", exp_q.size(), 0);
    chk(ctu_err_o == 0, "R9 no error when in time", ctu_err_o, 0);

    deadline_read(28'h800, 8398);   // completes in the last allowed cycle
    chk(ctu_err_o == 0, "R9 boundary completion no error", ctu_err_o, 0);

    deadline_read(28'h900, 8399);   // one cycle late
    chk(ctu_err_o == 1, "R9 overrun raises error", ctu_err_o, 1);
    do_batch(0, 1, 2, 28'hA00, 0, 0, 0, 0);
    chk(ctu_err_o == 1, "R9 error sticky", ctu_err_o, 1);
    chk(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);

    cyc(); rst_ni = 0; smp();
    chk(ctu_err_o == 0 && mem_req_o == 0 && desc_ready_o == 1, "R10 reset clears error",
        {ctu_err_o, mem_req_o, desc_ready_o}, 3'b001);
    cyc(); rst_ni = 1; smp();
    finish_run();
  end
endmodule